// File: doc/BRIEF.md
# Dual-Rate Bus Entry Waveform Generator

This block borrows the two wires of a two-wire bus, one clock line and one data line, and plays a fixed entry pattern on them. An attached target watches for this pattern to switch itself into a firmware-update mode. A start pulse takes the pins away from the normal I2C controller. The block then holds both lines at a configurable pre level for a set time. Next it runs a burst in which each line toggles as its own square wave: 100 kHz on the clock line and 200 kHz on the data line by default. Both lines then drop to a configurable post level for a settling time. Last, the block hands the pins back, and the burst counters stay stopped from then on.

All timing runs on a 1 MHz tick, which is divided down from the system clock. Each channel is a reload counter paired with a compare value. During the burst the compare is half the period. Outside the burst the compare is forced to zero, which gives a steady low, or to all ones, which gives a steady high. The default phase lengths are 5 ms pre, 50 ms burst and 10 ms post. The pre and post levels default to low.

Top module: `hs_wavegen`

## Requirements
- R1: After reset, busy_o and done_o are 0, pins_to_i2c_o is 1, and each line output sits at its post level.
- R2: start_i sampled high while idle makes busy_o 1 and pins_to_i2c_o 0 from the next cycle, with each line at its pre level (PRE_CLK_LVL, PRE_DAT_LVL).
- R3: The prescaler restarts on an accepted start and emits one tick every CLK_HZ/1_000_000 cycles. The pre phase lasts PRE_US ticks.
- R4: The burst follows the pre phase directly. Both channel counters clear at its first cycle. With a period of P = 1_000_000/f ticks (f = CLK_LINE_HZ or DAT_LINE_HZ), a line is high in tick t of the burst when (t mod P) < P/2 (integer division), and low otherwise.
- R5: The burst lasts BURST_US ticks. It is followed by POST_US ticks with each line at its post level (POST_CLK_LVL, POST_DAT_LVL).
- R6: In the cycle after the last post tick, done_o is 1 for exactly one cycle, busy_o falls to 0 and pins_to_i2c_o rises to 1. The lines stay at their post levels.
- R7: start_i while busy_o is 1 has no effect on any output.
- R8: After a handover, a new start replays the identical sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin the entry sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at handover |
| pins_to_i2c_o | output | 1 | Pin mux select: 1 gives the pins to the I2C controller |
| clk_line_o | output | 1 | Waveform for the bus clock line |
| dat_line_o | output | 1 | Waveform for the bus data line |

## Verification
The bench predicts every output in every cycle of two full sequences. It runs with the pre levels different on the two lines and the post levels swapped, so a design that swapped the pre and post settings, or mixed up the two channels, is caught. The bench checks the burst cycle by cycle. A design that left the counters running across the pre phase, or failed to restart the prescaler, would show wave edges shifted by whole ticks or by part of a tick. A design that took the compare as the full period instead of half would show the wrong duty. Start pulses are injected in the pre phase and in mid-burst. A design that restarted on them would put the lines back at their pre level and lengthen the sequence, which the bench sees at done.

// File: rtl/hs_wavegen_pkg.sv
package hs_wavegen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_BURST = 2'd2,
    PH_POST  = 2'd3
  } phase_e;

  localparam int unsigned TICK_HZ = 1_000_000;
  localparam int unsigned CMP_W   = 16;
endpackage

// File: rtl/hs_tick_div.sv
module hs_tick_div #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = (cnt_q == CW'(DIV - 1));
      assign tick_o = run_i && wrap;

      always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (run_i)          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end

      // R3: ticks never come on back-to-back cycles when dividing
      a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/hs_pwm_chan.sv
module hs_pwm_chan
  import hs_wavegen_pkg::*;
#(
  parameter int unsigned PERIOD = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic             line_o
);
  localparam int unsigned RELOAD = PERIOD - 1;

  logic [CMP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)       cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= (cnt_q == CMP_W'(RELOAD)) ? '0 : cnt_q + 1'b1;
  end

  // compare of zero yields constant low, all ones yields constant high
  assign line_o = (cnt_q < cmp_i);

  // R4: counter stays inside its reload range
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMP_W'(RELOAD));

  // R4: counter only moves on a tick or a clear
  a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hs_phase_seq.sv
module hs_phase_seq
  import hs_wavegen_pkg::*;
#(
  parameter int unsigned PRE_T   = 5000,
  parameter int unsigned BURST_T = 50000,
  parameter int unsigned POST_T  = 10000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   done_o,
  output logic   restart_o,
  output logic   burst_clr_o
);
  localparam int unsigned MAX_AB = (PRE_T > BURST_T) ? PRE_T : BURST_T;
  localparam int unsigned MAX_T  = (MAX_AB > POST_T) ? MAX_AB : POST_T;
  localparam int unsigned TW     = $clog2(MAX_T + 1);

  phase_e          phase_q;
  logic [TW-1:0]   tmr_q;
  logic [TW-1:0]   len_m1;
  logic            last;
  logic            done_q;

  always_comb begin
    case (phase_q)
      PH_PRE:   len_m1 = TW'(PRE_T - 1);
      PH_BURST: len_m1 = TW'(BURST_T - 1);
      default:  len_m1 = TW'(POST_T - 1);
    endcase
  end

  assign last        = (tmr_q == len_m1);
  assign restart_o   = (phase_q == PH_IDLE) && start_i;
  assign burst_clr_o = (phase_q == PH_PRE) && tick_i && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        tmr_q <= '0;
        if (start_i) phase_q <= PH_PRE;
      end else if (tick_i) begin
        if (last) begin
          tmr_q <= '0;
          case (phase_q)
            PH_PRE:   phase_q <= PH_BURST;
            PH_BURST: phase_q <= PH_POST;
            default: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R3: an active phase only advances on a tick
  a_r3_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !tick_i) |=> $stable(phase_q));

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a running burst never falls back to the pre phase
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BURST) |=> (phase_q != PH_PRE));
endmodule

// File: rtl/hs_wavegen.sv
module hs_wavegen
  import hs_wavegen_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned CLK_LINE_HZ  = 100_000,
  parameter int unsigned DAT_LINE_HZ  = 200_000,
  parameter int unsigned PRE_US       = 5_000,
  parameter int unsigned BURST_US     = 50_000,
  parameter int unsigned POST_US      = 10_000,
  parameter bit          PRE_CLK_LVL  = 1'b0,
  parameter bit          PRE_DAT_LVL  = 1'b0,
  parameter bit          POST_CLK_LVL = 1'b0,
  parameter bit          POST_DAT_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic pins_to_i2c_o,
  output logic clk_line_o,
  output logic dat_line_o
);
  localparam int unsigned DIV     = CLK_HZ / TICK_HZ;
  localparam int unsigned CLK_PER = TICK_HZ / CLK_LINE_HZ;
  localparam int unsigned DAT_PER = TICK_HZ / DAT_LINE_HZ;
  localparam int unsigned NCH     = 2;

  phase_e phase;
  logic   tick, restart, burst_clr, busy;
  logic [NCH-1:0] line;

  assign busy = (phase != PH_IDLE);

  hs_tick_div #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (busy),
    .tick_o    (tick)
  );

  hs_phase_seq #(
    .PRE_T   (PRE_US),
    .BURST_T (BURST_US),
    .POST_T  (POST_US)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tick_i      (tick),
    .phase_o     (phase),
    .done_o      (done_o),
    .restart_o   (restart),
    .burst_clr_o (burst_clr)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int unsigned PER  = (g == 0) ? CLK_PER : DAT_PER;
      localparam bit          PRE  = (g == 0) ? PRE_CLK_LVL  : PRE_DAT_LVL;
      localparam bit          POST = (g == 0) ? POST_CLK_LVL : POST_DAT_LVL;

      logic [CMP_W-1:0] cmp;

      always_comb begin
        case (phase)
          PH_BURST: cmp = CMP_W'(PER / 2);
          PH_PRE:   cmp = PRE  ? '1 : '0;
          default:  cmp = POST ? '1 : '0;
        endcase
      end

      hs_pwm_chan #(.PERIOD(PER)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (burst_clr),
        .run_i  (phase == PH_BURST),
        .tick_i (tick),
        .cmp_i  (cmp),
        .line_o (line[g])
      );
    end
  endgenerate

  assign busy_o        = busy;
  assign pins_to_i2c_o = !busy;
  assign clk_line_o    = line[0];
  assign dat_line_o    = line[1];

  // R2: both lines pinned to their pre levels during the pre phase
  a_r2_pre_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE) |-> (clk_line_o == PRE_CLK_LVL && dat_line_o == PRE_DAT_LVL));

  // R6: pins return to the I2C controller together with the done pulse
  a_r6_handover_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_to_i2c_o) |-> done_o);
endmodule

// File: tb/hs_wavegen_bench.sv
module hs_wavegen_bench;
  localparam int CLK_HZ = 50_000_000;
  localparam int DIV    = 50;
  localparam int PRE    = 20;
  localparam int BURST  = 60;
  localparam int POST   = 30;
  localparam int P_CLK  = 10;   // 1 MHz / 100 kHz
  localparam int P_DAT  = 5;    // 1 MHz / 200 kHz
  localparam bit PRE_C  = 1'b1, PRE_D  = 1'b0;
  localparam bit POST_C = 1'b0, POST_D = 1'b1;
  localparam int N      = (PRE + BURST + POST) * DIV;

  typedef struct {
    logic [4:0] v;   // busy, done, handover, clk line, data line
    string      tag;
    int         idx;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, pins_to_i2c_o, clk_line_o, dat_line_o;

  int errors = 0;
  int checks = 0;
  item_t q[$];

  always #10 clk = ~clk;

  hs_wavegen #(
    .CLK_HZ(CLK_HZ), .CLK_LINE_HZ(100_000), .DAT_LINE_HZ(200_000),
    .PRE_US(PRE), .BURST_US(BURST), .POST_US(POST),
    .PRE_CLK_LVL(PRE_C), .PRE_DAT_LVL(PRE_D),
    .POST_CLK_LVL(POST_C), .POST_DAT_LVL(POST_D)
  ) u_hs_wavegen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .pins_to_i2c_o(pins_to_i2c_o),
    .clk_line_o(clk_line_o), .dat_line_o(dat_line_o)
  );

  function automatic logic [4:0] expect_at(int k);
    int t;
    if (k < PRE * DIV) return {3'b100, PRE_C, PRE_D};
    if (k < (PRE + BURST) * DIV) begin
      t = (k - PRE * DIV) / DIV;
      return {3'b100, ((t % P_CLK) < P_CLK / 2), ((t % P_DAT) < P_DAT / 2)};
    end
    if (k < N)  return {3'b100, POST_C, POST_D};
    if (k == N) return {3'b011, POST_C, POST_D};
    return {3'b001, POST_C, POST_D};
  endfunction

  function automatic string tag_at(int k, int run);
    if (run == 2 && k == 0)      return "R8";
    if (k == 0)                  return "R2";
    if (k < PRE * DIV)           return "R3 R7";
    if (k < (PRE + BURST) * DIV) return "R4 R7";
    if (k < N)                   return "R5";
    return "R6";
  endfunction

  // driver: start a sequence and queue what every following cycle must show
  task automatic run_seq(int run, bit poke);
    item_t it;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= N + 1; k++) begin
      it.v = expect_at(k); it.tag = tag_at(k, run); it.idx = k;
      q.push_back(it);
    end
    @(negedge clk) start_i = 1'b0;
    if (poke) begin
      // R7: start pulses in the pre phase and mid-burst must be ignored
      repeat (300) @(negedge clk);
      start_i = 1'b1; @(negedge clk) start_i = 1'b0;
      repeat (2000) @(negedge clk);
      start_i = 1'b1; @(negedge clk) start_i = 1'b0;
    end
    wait (q.size() == 0);
    repeat (5) @(negedge clk);
  endtask

  // monitor: compare outputs away from the active edge
  initial begin
    item_t it;
    logic [4:0] act;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        act = {busy_o, done_o, pins_to_i2c_o, clk_line_o, dat_line_o};
        checks++;
        if (act !== it.v) begin
          errors++;
          $display("FAIL %s cycle %0d: actual=%b expected=%b", it.tag, it.idx, act, it.v);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100_000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if ({busy_o, done_o, pins_to_i2c_o, clk_line_o, dat_line_o} !== {3'b001, POST_C, POST_D}) begin
      errors++;
      $display("FAIL R1 reset: actual=%b expected=%b",
               {busy_o, done_o, pins_to_i2c_o, clk_line_o, dat_line_o}, {3'b001, POST_C, POST_D});
    end
    run_seq(1, 1'b1);
    run_seq(2, 1'b0);   // R8: replay after handover
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule